// File: doc/BRIEF.md
# NAND Flash Operation Engine

This block sits between a host register interface and a parallel NAND flash device. The host loads a command byte, an address byte, an area select and a configuration word, then starts exactly one primitive flash operation by writing a single launch bit into the control register. The primitives are a command latch, an address latch, a buffer-to-flash page program transfer, a flash-to-buffer page read transfer, an identification read and a status read. The engine drives the latch-enable, strobe and chip-enable lines of the flash, then waits for the device ready/busy line to return high. Only then does it raise a sticky completion flag.

Page data is staged in an internal byte buffer. The buffer is split into four numbered main areas, each with its own small spare area. The spare areas sit together after all the main areas. The host reaches the buffer through a 16-bit word port. A configuration bit selects how the two bytes of each word are ordered.

Top module: `nand_op_engine`

## Requirements
- R1: After reset, and whenever the engine is idle, CLE and ALE are low and WE# and RE# are high. The control register (select 4) reads zero after reset.
- R2: Launch value 0x0001 in the control register gives one WE# pulse with CLE high and ALE low. The I/O bus carries the low byte of the command register (select 0) during that pulse.
- R3: Launch value 0x0002 gives one WE# pulse with ALE high and CLE low. The I/O bus carries the low byte of the address register (select 1). CLE and ALE are never high together.
- R4: Launch value 0x0008 gives RE# pulses and stores one captured byte per pulse into consecutive buffer bytes of the area chosen by the area register (select 2). With configuration bit 2 clear, it stores the area's main bytes first and then its spare bytes. With bit 2 set, it stores only the spare bytes and leaves the main bytes unchanged.
- R5: Launch value 0x0004 gives WE# pulses with CLE and ALE low. Each pulse drives the next buffer byte of the selected area, in the same order and length as R4.
- R6: Launch value 0x0010 captures ID_BYTES bytes into main area 0, starting at byte 0, whatever area is selected.
- R7: Launch value 0x0020 captures one byte into the first byte of the selected main area. The second byte of that word is left unchanged.
- R8: Bit 15 of the control register is the completion flag. It is set when an operation ends and stays set. Writing the register with bit 15 at 0 clears it. Writing a 1 to bit 15 never sets it.
- R9: The completion flag is not set while the ready/busy input is low. It is set only after that input returns high, once the final strobe has ended.
- R10: Bit 14 of the control register reads 1 while an operation runs. A launch write made while busy is ignored, and so is a write with more than one launch bit set. Bits 5:0 read back the last accepted operation.
- R11: Host word w maps to buffer bytes 2w and 2w+1. With configuration bit 5 clear, byte 2w is in the low half of the word. With bit 5 set, the two halves are swapped, for both reads and writes.
- R12: Configuration bit 7 forces CE# low. CE# is also low throughout any operation. Writing configuration bit 6 as 1 aborts the operation in progress and clears the completion flag. Bit 6 reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 command, 1 address, 2 area, 3 configuration, 4 control |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational, selected by reg_sel) |
| buf_en | input | 1 | Buffer port access enable |
| buf_we | input | 1 | Buffer port write (1) or read (0) |
| buf_waddr | input | clog2(AREAS*(AREA_BYTES+SPARE_BYTES)/2) | Buffer word address |
| buf_wdata | input | 16 | Buffer write word |
| buf_rdata | output | 16 | Buffer read word, one cycle after the request |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_ce_n | output | 1 | Chip enable, active low |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_rb_n | input | 1 | Ready (high) / busy (low) from the device |
| nf_dout | output | 8 | I/O bus value driven toward the device |
| nf_doe | output | 1 | I/O bus output enable |
| nf_din | input | 8 | I/O bus value from the device |

## Verification
The bench builds the engine with 8-byte main areas, 4-byte spare areas, four areas, a 4-byte identification read, a two-cycle strobe and a three-cycle guard before the ready/busy line is sampled. At these sizes a full main-plus-spare transfer takes twelve strobes. Every byte can therefore be compared against the scoreboard, and every word of an area can be read back through the host port. The area boundary, the jump into the spare region and the spare-only path are all reached within a few hundred cycles. Holding ready/busy low for forty cycles exposes the gap between the last strobe and the completion flag. That window is also used to make launch and abort writes while the engine is busy.

// File: rtl/nand_op_engine.sv
module nand_op_engine #(
  parameter int AREA_BYTES  = 512,
  parameter int SPARE_BYTES = 16,
  parameter int AREAS       = 4,
  parameter int ID_BYTES    = 5,
  parameter int PULSE_W     = 2,
  parameter int RB_GUARD    = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_sel,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        buf_en,
  input  logic        buf_we,
  input  logic [$clog2(AREAS*(AREA_BYTES+SPARE_BYTES)/2)-1:0] buf_waddr,
  input  logic [15:0] buf_wdata,
  output logic [15:0] buf_rdata,
  output logic        nf_cle,
  output logic        nf_ale,
  output logic        nf_ce_n,
  output logic        nf_we_n,
  output logic        nf_re_n,
  input  logic        nf_rb_n,
  output logic [7:0]  nf_dout,
  output logic        nf_doe,
  input  logic [7:0]  nf_din
);
  localparam int MAIN_TOT  = AREAS * AREA_BYTES;
  localparam int BUF_BYTES = MAIN_TOT + AREAS * SPARE_BYTES;
  localparam int WA_W      = $clog2(BUF_BYTES / 2);
  localparam int BA_W      = WA_W + 1;
  localparam int AS_W      = $clog2(AREAS);
  localparam int XFER_MAX  = AREA_BYTES + SPARE_BYTES;
  localparam int MAXB      = (XFER_MAX > ID_BYTES) ? XFER_MAX : ID_BYTES;
  localparam int CNT_W     = $clog2(MAXB + 1);
  localparam int TMAX      = (PULSE_W > RB_GUARD) ? PULSE_W : RB_GUARD;
  localparam int TW        = $clog2(TMAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_STROBE, S_WAIT} st_t;

  st_t              st;
  logic [7:0]       mem [BUF_BYTES];
  logic [15:0]      cmd_q, addr_q, cfg1_q;
  logic [AS_W-1:0]  area_q;
  logic [5:0]       op_q;
  logic             flag_q;
  logic [CNT_W-1:0] cnt;
  logic [TW-1:0]    tcnt;
  logic [BA_W-1:0]  eidx;

  wire busy      = (st != S_IDLE);
  wire drive     = (st == S_SETUP) || (st == S_STROBE);
  wire sp_only   = cfg1_q[2];
  wire big_end   = cfg1_q[5];
  wire is_rd     = op_q[3] | op_q[4] | op_q[5];
  wire is_xfer   = op_q[2] | op_q[3];
  wire pulse_end = (tcnt == TW'(PULSE_W - 1));
  wire [CNT_W-1:0] xfer_len  = sp_only ? CNT_W'(SPARE_BYTES) : CNT_W'(XFER_MAX);
  wire [CNT_W-1:0] n_bytes   = is_xfer ? xfer_len : (op_q[4] ? CNT_W'(ID_BYTES) : CNT_W'(1));
  wire [CNT_W-1:0] last_byte = n_bytes - 1'b1;
  wire launch    = reg_wr && (reg_sel == 3'd4) && !busy && $onehot(reg_wdata[5:0]);
  wire eng_wr    = (st == S_STROBE) && pulse_end && is_rd;
  wire [BA_W-1:0] hb_lo = {buf_waddr, 1'b0};
  wire [BA_W-1:0] hb_hi = {buf_waddr, 1'b1};

  always_comb begin
    if (op_q[4])
      eidx = BA_W'(cnt);
    else if (op_q[5])
      eidx = BA_W'(area_q * AREA_BYTES);
    else if (!sp_only && cnt < CNT_W'(AREA_BYTES))
      eidx = BA_W'(area_q * AREA_BYTES) + BA_W'(cnt);
    else
      eidx = BA_W'(MAIN_TOT + area_q * SPARE_BYTES) + BA_W'(cnt)
             - (sp_only ? BA_W'(0) : BA_W'(AREA_BYTES));
  end

  always_ff @(posedge clk) begin
    if (buf_en && buf_we) begin
      mem[hb_lo] <= big_end ? buf_wdata[15:8] : buf_wdata[7:0];
      mem[hb_hi] <= big_end ? buf_wdata[7:0]  : buf_wdata[15:8];
    end
    if (eng_wr) mem[eidx] <= nf_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) buf_rdata <= '0;
    else if (buf_en && !buf_we)
      buf_rdata <= big_end ? {mem[hb_lo], mem[hb_hi]} : {mem[hb_hi], mem[hb_lo]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cmd_q <= '0; addr_q <= '0; cfg1_q <= '0; area_q <= '0;
      op_q <= '0; flag_q <= 1'b0; cnt <= '0; tcnt <= '0;
    end else begin
      case (st)
        S_SETUP: begin st <= S_STROBE; tcnt <= '0; end
        S_STROBE:
          if (pulse_end) begin
            tcnt <= '0;
            if (cnt == last_byte) st <= S_WAIT;
            else begin cnt <= cnt + 1'b1; st <= S_SETUP; end
          end else tcnt <= tcnt + 1'b1;
        S_WAIT:
          if (tcnt != TW'(RB_GUARD)) tcnt <= tcnt + 1'b1;
          else if (nf_rb_n) begin flag_q <= 1'b1; st <= S_IDLE; end
        default: ;
      endcase
      if (reg_wr) begin
        case (reg_sel)
          3'd0: cmd_q  <= reg_wdata;
          3'd1: addr_q <= reg_wdata;
          3'd2: area_q <= reg_wdata[AS_W-1:0];
          3'd3: begin
            cfg1_q <= reg_wdata & ~16'h0040;
            if (reg_wdata[6]) begin st <= S_IDLE; flag_q <= 1'b0; end
          end
          3'd4: begin
            if (!reg_wdata[15]) flag_q <= 1'b0;
            if (launch) begin
              op_q <= reg_wdata[5:0]; st <= S_SETUP; cnt <= '0; tcnt <= '0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_sel)
      3'd0:    reg_rdata = cmd_q;
      3'd1:    reg_rdata = addr_q;
      3'd2:    reg_rdata = 16'(area_q);
      3'd3:    reg_rdata = cfg1_q;
      3'd4:    reg_rdata = {flag_q, busy, 8'b0, op_q};
      default: reg_rdata = '0;
    endcase
  end

  assign nf_cle  = op_q[0] && drive;
  assign nf_ale  = op_q[1] && drive;
  assign nf_we_n = !((st == S_STROBE) && !is_rd);
  assign nf_re_n = !((st == S_STROBE) && is_rd);
  assign nf_ce_n = !(busy || cfg1_q[7]);
  assign nf_doe  = drive && !is_rd;
  assign nf_dout = op_q[0] ? cmd_q[7:0] : (op_q[1] ? addr_q[7:0] : mem[eidx]);

  assert_lines_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (nf_we_n && nf_re_n && !nf_cle && !nf_ale));
  assert_latch_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(nf_cle && nf_ale));
  assert_flag_after_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(nf_rb_n));
  assert_busy_launch_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_sel == 3'd4) |=> $stable(op_q));
  assert_ce_while_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !nf_ce_n);
endmodule

// File: tb/tb_nand_op_engine.sv
module tb_nand_op_engine;
  localparam int AB = 8, SB = 4, NA = 4, IDB = 4;
  localparam int WA = $clog2(NA * (AB + SB) / 2);

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0; logic [2:0] reg_sel = 0; logic [15:0] reg_wdata = 0, reg_rdata;
  logic buf_en = 0, buf_we = 0; logic [WA-1:0] buf_waddr = 0;
  logic [15:0] buf_wdata = 0, buf_rdata;
  logic nf_cle, nf_ale, nf_ce_n, nf_we_n, nf_re_n, nf_doe;
  logic nf_rb_n = 1; logic [7:0] nf_dout, nf_din;

  int nchk = 0, nerr = 0; bit done_run = 0;
  logic [9:0] exp_q[$];
  logic we_prev = 1, re_prev = 1; int rd_idx = 0;

  always #5 clk = ~clk;
  assign nf_din = 8'(8'hA0 + rd_idx);

  nand_op_engine #(.AREA_BYTES(AB), .SPARE_BYTES(SB), .AREAS(NA), .ID_BYTES(IDB),
                   .PULSE_W(2), .RB_GUARD(3)) dut (
    .clk, .rst_n, .reg_wr, .reg_sel, .reg_wdata, .reg_rdata, .buf_en, .buf_we,
    .buf_waddr, .buf_wdata, .buf_rdata, .nf_cle, .nf_ale, .nf_ce_n, .nf_we_n,
    .nf_re_n, .nf_rb_n, .nf_dout, .nf_doe, .nf_din);

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // monitor: flash model and strobe scoreboard (R2, R3, R5)
  always @(negedge clk) begin
    if (!nf_we_n && we_prev) begin
      if (exp_q.size() == 0) check("R5 unexpected write strobe", {6'b0, nf_cle, nf_ale, nf_dout}, 16'hFFFF);
      else check("R2/R3/R5 strobe", {6'b0, nf_cle, nf_ale, nf_dout}, {6'b0, exp_q.pop_front()});
    end
    if (nf_re_n && !re_prev) rd_idx++;
    we_prev = nf_we_n; re_prev = nf_re_n;
  end

  task automatic wr(input logic [2:0] s, input logic [15:0] d);
    @(negedge clk); reg_wr = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask
  task automatic rd(input logic [2:0] s, output logic [15:0] d);
    @(negedge clk); reg_sel = s; #1 d = reg_rdata;
  endtask
  task automatic bwr(input int w, input logic [15:0] d);
    @(negedge clk); buf_en = 1; buf_we = 1; buf_waddr = WA'(w); buf_wdata = d;
    @(negedge clk); buf_en = 0; buf_we = 0;
  endtask
  task automatic brd(input int w, output logic [15:0] d);
    @(negedge clk); buf_en = 1; buf_we = 0; buf_waddr = WA'(w);
    @(negedge clk); d = buf_rdata; buf_en = 0;
  endtask
  task automatic wait_done();
    logic [15:0] v;
    for (int i = 0; i < 400; i++) begin rd(4, v); if (v[15]) break; end
  endtask
  task automatic run(input logic [15:0] launch);
    wr(4, launch); wait_done(); wr(4, 16'h0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog: got timeout expected completion");
    if (!done_run) begin
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [15:0] v; int b;
    repeat (3) @(negedge clk); rst_n = 1;
    // R1 reset state
    rd(4, v); check("R1 control after reset", v, 16'h0000);
    check("R1 idle pins", {12'b0, nf_cle, nf_ale, nf_we_n, nf_re_n}, 16'h0003);

    // R2 command latch, R8 sticky flag
    wr(0, 16'h5570); exp_q.push_back({2'b10, 8'h70});
    wr(4, 16'h0001); wait_done();
    rd(4, v); check("R8 flag set, not busy", {14'b0, v[15:14]}, 16'h0002);
    repeat (5) @(negedge clk);
    rd(4, v); check("R8 flag sticky", {15'b0, v[15]}, 16'h0001);
    wr(4, 16'h0000); rd(4, v); check("R8 flag cleared", {15'b0, v[15]}, 16'h0000);
    wr(4, 16'h8000); rd(4, v); check("R8 writing one does not set", {15'b0, v[15]}, 16'h0000);

    // R3 address latch
    wr(1, 16'h1234); exp_q.push_back({2'b01, 8'h34}); run(16'h0002);

    // R5 + R11: program transfer from area 2, main then spare
    for (int i = 0; i < 4; i++) bwr(8 + i, {8'(8'h51 + 2*i), 8'(8'h50 + 2*i)});
    for (int i = 0; i < 2; i++) bwr(20 + i, {8'(8'h61 + 2*i), 8'(8'h60 + 2*i)});
    wr(2, 16'h0002); wr(3, 16'h0000);
    for (int k = 0; k < 8; k++) exp_q.push_back({2'b00, 8'(8'h50 + k)});
    for (int k = 0; k < 4; k++) exp_q.push_back({2'b00, 8'(8'h60 + k)});
    run(16'h0004);
    // R5 spare-only program
    wr(3, 16'h0004);
    for (int k = 0; k < 4; k++) exp_q.push_back({2'b00, 8'(8'h60 + k)});
    run(16'h0004);
    check("R5 strobes all consumed", 16'(exp_q.size()), 16'h0000);

    // R4 full read into area 1
    wr(3, 16'h0000); wr(2, 16'h0001); b = rd_idx; run(16'h0008);
    for (int i = 0; i < 4; i++) begin
      brd(4 + i, v); check("R4 main bytes", v, {8'(8'hA1 + b + 2*i), 8'(8'hA0 + b + 2*i)});
    end
    for (int i = 0; i < 2; i++) begin
      brd(18 + i, v); check("R4 spare bytes", v, {8'(8'hA9 + b + 2*i), 8'(8'hA8 + b + 2*i)});
    end
    // R4 spare-only read into area 3, main untouched
    bwr(12, 16'hBEEF); wr(3, 16'h0004); wr(2, 16'h0003); b = rd_idx; run(16'h0008);
    for (int i = 0; i < 2; i++) begin
      brd(22 + i, v); check("R4 spare-only bytes", v, {8'(8'hA1 + b + 2*i), 8'(8'hA0 + b + 2*i)});
    end
    brd(12, v); check("R4 main untouched in spare-only", v, 16'hBEEF);

    // R6 ID into area 0 regardless of area select
    wr(3, 16'h0000); b = rd_idx; run(16'h0010);
    for (int i = 0; i < 2; i++) begin
      brd(i, v); check("R6 id bytes", v, {8'(8'hA1 + b + 2*i), 8'(8'hA0 + b + 2*i)});
    end

    // R7 status into first byte of area 1
    bwr(4, 16'h7E7E); wr(2, 16'h0001); b = rd_idx; run(16'h0020);
    brd(4, v); check("R7 status byte", v, {8'h7E, 8'(8'hA0 + b)});

    // R11 byte order swap
    wr(3, 16'h0020); brd(4, v); check("R11 swapped read", v, {8'(8'hA0 + b), 8'h7E});
    bwr(5, 16'h1234); wr(3, 16'h0000); brd(5, v); check("R11 swapped write", v, 16'h3412);

    // R9 wait for ready, R10 ignored launch while busy
    nf_rb_n = 0; wr(0, 16'h0090); exp_q.push_back({2'b10, 8'h90});
    wr(4, 16'h0001); repeat (40) @(negedge clk);
    rd(4, v); check("R9 no flag while device busy", {14'b0, v[15:14]}, 16'h0001);
    wr(4, 16'h0002); rd(4, v); check("R10 launch ignored while busy", {10'b0, v[5:0]}, 16'h0001);
    nf_rb_n = 1; wait_done();
    rd(4, v); check("R9 flag after ready", {14'b0, v[15:14]}, 16'h0002);
    wr(4, 16'h0000);
    wr(4, 16'h0003); repeat (5) @(negedge clk);
    rd(4, v); check("R10 multi-bit launch ignored", {9'b0, v[14], v[5:0]}, 16'h0001);

    // R12 forced chip enable and abort
    wr(3, 16'h0080); check("R12 forced CE", {15'b0, nf_ce_n}, 16'h0000);
    wr(3, 16'h0000); check("R12 CE released", {15'b0, nf_ce_n}, 16'h0001);
    nf_rb_n = 0; wr(0, 16'h00FF); exp_q.push_back({2'b10, 8'hFF});
    wr(4, 16'h0001); repeat (20) @(negedge clk);
    wr(3, 16'h0040);
    rd(4, v); check("R12 abort clears busy and flag", {14'b0, v[15:14]}, 16'h0000);
    rd(3, v); check("R12 reset bit reads zero", v, 16'h0000);
    check("R12 CE high after abort", {15'b0, nf_ce_n}, 16'h0001);
    nf_rb_n = 1;
    check("R5 scoreboard drained", 16'(exp_q.size()), 16'h0000);

    done_run = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule